// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier with Parallel Test Mode

This block sits on the device side of an asynchronous DRAM interface. It samples the active-low row strobe, column strobe and write strobe on a fast system clock through two-stage synchronizers. From the order in which the strobes move, it names every row cycle as one of four kinds: an ordinary access, a row-only refresh, a column-before-row refresh, or a test-mode entry. It reports each kind with a single-clock pulse and a two-bit code.

The block also holds a latched parallel-test flag. A test-entry cycle sets the flag. Access cycles do not touch it, and either refresh kind clears it. During a read, the block takes the data group that the array presents for the addressed column group. In normal mode it drives out the one word that the low column bits select. In test mode it ignores those column bits, compares every bit of the group, and drives out all ones when the bits agree and all zeros when any bit differs. A test-mode read reaches the pins one clock later than a normal read. An early write leaves the data drivers off.

Top module: `dram_cycle_classifier`

## Requirements
- R1: After reset, `cyc_valid`, `test_mode` and `dq_oe` are all low.
- R2: If the synchronized column strobe is low in the sample where the row strobe is first seen low, and the write strobe is high, one pulse with code 2 (column-before-row refresh) is issued. This also holds when both strobes fall in the same sample, and when the column strobe is held low from the previous cycle (hidden refresh).
- R3: If both the column strobe and the write strobe are low when the row strobe falls, one pulse with code 3 (test entry) is issued and `test_mode` goes high.
- R4: `test_mode` keeps its value through any number of access cycles, whether read or write.
- R5: If the column strobe is high when the row strobe falls and does not fall before the row strobe rises, one pulse with code 1 (row-only refresh) is issued when the row strobe rises. Both refresh kinds (code 1 and code 2) clear `test_mode`.
- R6: If the column strobe is high when the row strobe falls and then falls while the row strobe is low, exactly one pulse with code 0 (access) is issued for that row cycle, however many column pulses follow.
- R7: In a normal-mode read, `dq_out` equals word `col_lo` of `rd_group`, where word i occupies bits [i*WORD_W +: WORD_W]. `dq_oe` rises on the 4th rising clock edge after the column strobe input falls.
- R8: In a test-mode read, `dq_out` is all ones if every bit of `rd_group` is equal and all zeros otherwise, whatever the value of `col_lo`. `dq_oe` rises on the 5th rising edge, one clock later than in R7.
- R9: If the write strobe is low when the column strobe fall is sampled (early write), `dq_oe` stays low for the whole cycle.
- R10: After the row strobe input rises, `dq_oe` is low by the 4th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| col_lo | input | SEL_W | Low column address bits, stable around the column strobe fall |
| rd_group | input | GROUP_W | Array data for the addressed column group |
| cyc_valid | output | 1 | One-clock pulse when a cycle is classified |
| cyc_type | output | 2 | 0 access, 1 row-only refresh, 2 column-before-row refresh, 3 test entry |
| test_mode | output | 1 | Latched parallel-test flag |
| dq_out | output | WORD_W | Read data or compressed test result |
| dq_oe | output | 1 | Data output drive enable |

## Verification
The bench sweeps every mix of column and write strobe levels at the row fall, with and without a column pulse, starting from both states of the test flag. A decoder that confused the two refresh kinds, cleared the flag on an access, or left it set after a refresh shows a wrong code or a wrong flag. Other runs cover both strobes falling in the same sample, where a decoder that waited for a later column fall would report an access instead of a refresh, and a page cycle with two column pulses, where a decoder that reported one access per pulse would issue a second pulse. The read runs measure the latency in clocks, so a missing or extra test-mode delay stage is caught. They also use groups that differ in a single bit, which a compare that skipped part of the group would wrongly pass.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    CYC_ACCESS   = 2'd0,
    CYC_ROW_ONLY = 2'd1,
    CYC_CBR      = 2'd2,
    CYC_TEST     = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/dcc_strobe_sync.sv
module dcc_strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] synced
);
  logic [N-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)         chain[s] <= '1;
        else if (s == 0) chain[s] <= raw;
        else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/dcc_cycle_decode.sv
module dcc_cycle_decode
  import dcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ras_s,
  input  logic      cas_s,
  input  logic      we_s,
  output logic      cyc_valid,
  output cyc_kind_e cyc_type,
  output logic      test_mode,
  output logic      rd_go,
  output logic      rd_tm,
  output logic      drive_off
);
  logic ras_p, cas_p;
  logic pending, in_access;
  logic ras_fall, ras_rise, cas_fall;

  assign ras_fall = ras_p & ~ras_s;
  assign ras_rise = ~ras_p & ras_s;
  assign cas_fall = cas_p & ~cas_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_p     <= 1'b1;
      cas_p     <= 1'b1;
      pending   <= 1'b0;
      in_access <= 1'b0;
      test_mode <= 1'b0;
      cyc_valid <= 1'b0;
      cyc_type  <= CYC_ACCESS;
      rd_go     <= 1'b0;
      rd_tm     <= 1'b0;
      drive_off <= 1'b0;
    end else begin
      ras_p     <= ras_s;
      cas_p     <= cas_s;
      cyc_valid <= 1'b0;
      rd_go     <= 1'b0;
      drive_off <= 1'b0;
      if (ras_fall) begin
        in_access <= 1'b0;
        if (!cas_s && !we_s) begin
          cyc_valid <= 1'b1;
          cyc_type  <= CYC_TEST;
          test_mode <= 1'b1;
        end else if (!cas_s) begin
          cyc_valid <= 1'b1;
          cyc_type  <= CYC_CBR;
          test_mode <= 1'b0;
        end else begin
          pending <= 1'b1;
        end
      end else if (ras_rise) begin
        drive_off <= 1'b1;
        in_access <= 1'b0;
        pending   <= 1'b0;
        if (pending) begin
          cyc_valid <= 1'b1;
          cyc_type  <= CYC_ROW_ONLY;
          test_mode <= 1'b0;
        end
      end else if (cas_fall && !ras_s && (pending || in_access)) begin
        if (pending) begin
          cyc_valid <= 1'b1;
          cyc_type  <= CYC_ACCESS;
          pending   <= 1'b0;
          in_access <= 1'b1;
        end
        if (we_s) begin
          rd_go <= 1'b1;
          rd_tm <= test_mode;
        end else begin
          drive_off <= 1'b1;
        end
      end
    end
  end

  // R3: the flag only rises together with a test-entry report
  a_r3_entry_sets_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(test_mode) |-> (cyc_valid && cyc_type == CYC_TEST));

  // R5: the flag only falls together with a refresh report
  a_r5_refresh_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(test_mode) |-> (cyc_valid && (cyc_type == CYC_ROW_ONLY || cyc_type == CYC_CBR)));

  // R4: an access report never moves the flag
  a_r4_access_keeps_flag: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_type == CYC_ACCESS) |-> $stable(test_mode));
endmodule

// File: rtl/dcc_read_reduce.sv
module dcc_read_reduce #(
  parameter int WORD_W  = 4,
  parameter int GROUP_N = 4,
  localparam int SEL_W   = (GROUP_N > 1) ? $clog2(GROUP_N) : 1,
  localparam int GROUP_W = WORD_W * GROUP_N
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_go,
  input  logic               rd_tm,
  input  logic               drive_off,
  input  logic [SEL_W-1:0]   col_lo,
  input  logic [GROUP_W-1:0] rd_group,
  output logic [WORD_W-1:0]  dq_out,
  output logic               dq_oe
);
  logic              t_valid;
  logic              t_pass;
  logic [WORD_W-1:0] norm_word;

  assign norm_word = rd_group[col_lo*WORD_W +: WORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      t_valid <= 1'b0;
      t_pass  <= 1'b0;
      dq_out  <= '0;
      dq_oe   <= 1'b0;
    end else begin
      t_valid <= rd_go & rd_tm;
      if (rd_go && rd_tm) t_pass <= (&rd_group) | ~(|rd_group);
      if (drive_off) begin
        dq_oe <= 1'b0;
      end else if (rd_go && !rd_tm) begin
        dq_out <= norm_word;
        dq_oe  <= 1'b1;
      end else if (t_valid) begin
        dq_out <= {WORD_W{t_pass}};
        dq_oe  <= 1'b1;
      end
    end
  end

  // R8: a compressed result drives a uniform word
  a_r8_uniform_result: assert property (@(posedge clk) disable iff (rst)
    (t_valid && !drive_off) |=> (dq_oe && (dq_out == '0 || dq_out == '1)));

  // R9: a drive-off request leaves the pins undriven next clock
  a_r9_drive_off: assert property (@(posedge clk) disable iff (rst)
    drive_off |=> !dq_oe);
endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
  import dcc_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int GROUP_N     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W   = (GROUP_N > 1) ? $clog2(GROUP_N) : 1,
  localparam int GROUP_W = WORD_W * GROUP_N
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic [SEL_W-1:0]   col_lo,
  input  logic [GROUP_W-1:0] rd_group,
  output logic               cyc_valid,
  output logic [1:0]         cyc_type,
  output logic               test_mode,
  output logic [WORD_W-1:0]  dq_out,
  output logic               dq_oe
);
  logic [2:0] strobes_s;
  logic       rd_go, rd_tm, drive_off;
  cyc_kind_e  kind;

  dcc_strobe_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw    ({ras_n, cas_n, we_n}),
    .synced (strobes_s)
  );

  dcc_cycle_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .ras_s     (strobes_s[2]),
    .cas_s     (strobes_s[1]),
    .we_s      (strobes_s[0]),
    .cyc_valid (cyc_valid),
    .cyc_type  (kind),
    .test_mode (test_mode),
    .rd_go     (rd_go),
    .rd_tm     (rd_tm),
    .drive_off (drive_off)
  );

  assign cyc_type = kind;

  dcc_read_reduce #(.WORD_W(WORD_W), .GROUP_N(GROUP_N)) u_reduce (
    .clk       (clk),
    .rst       (rst),
    .rd_go     (rd_go),
    .rd_tm     (rd_tm),
    .drive_off (drive_off),
    .col_lo    (col_lo),
    .rd_group  (rd_group),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );
endmodule

// File: tb/dram_cycle_classifier_test.sv
module dram_cycle_classifier_test;
  localparam int WORD_W  = 4;
  localparam int GROUP_N = 4;
  localparam int SEL_W   = 2;
  localparam int GROUP_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [SEL_W-1:0]   col_lo = '0;
  logic [GROUP_W-1:0] rd_group = '0;
  logic               cyc_valid, test_mode, dq_oe;
  logic [1:0]         cyc_type;
  logic [WORD_W-1:0]  dq_out;

  int checks = 0;
  int errors = 0;
  int ncls = 0;
  int oe_seen = 0;
  logic [1:0] last_type = 2'd0;
  int cyc_count = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_cycle_classifier #(.WORD_W(WORD_W), .GROUP_N(GROUP_N)) uut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .col_lo(col_lo), .rd_group(rd_group), .cyc_valid(cyc_valid),
    .cyc_type(cyc_type), .test_mode(test_mode), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always @(negedge clk) begin
    if (!rst && cyc_valid) begin
      ncls++;
      last_type = cyc_type;
    end
    if (!rst && dq_oe) oe_seen++;
  end

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 150000", cyc_count);
      finish_up();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one row cycle: strobe levels before the row fall, optional column pulse
  task automatic row_cycle(input bit c_pre, input bit w_pre, input bit pulse, input bit w_cas);
    @(negedge clk); cas_n = c_pre; we_n = w_pre;
    wait_n(3);
    ras_n = 1'b0;
    wait_n(4);
    if (c_pre && pulse) begin
      we_n = w_cas;
      wait_n(1);
      cas_n = 1'b0; wait_n(6);
      cas_n = 1'b1; wait_n(3);
    end
    ras_n = 1'b1;
    wait_n(4);
    cas_n = 1'b1; we_n = 1'b1;
    wait_n(4);
  endtask

  // read in the current mode; returns the negedge count at which dq_oe rose
  task automatic read_cycle(input logic [SEL_W-1:0] col, input logic [GROUP_W-1:0] grp,
                            output int lat, output logic [WORD_W-1:0] word);
    @(negedge clk); cas_n = 1'b1; we_n = 1'b1;
    wait_n(3);
    ras_n = 1'b0; wait_n(4);
    col_lo = col; rd_group = grp;
    cas_n = 1'b0;
    lat = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (dq_oe && lat == 0) lat = k;
    end
    word = dq_out;
    cas_n = 1'b1; wait_n(2);
  endtask

  task automatic end_row(output int off_lat);
    ras_n = 1'b1;
    off_lat = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (!dq_oe && off_lat == 0) off_lat = k;
    end
    wait_n(3);
  endtask

  initial begin
    int lat, off_lat;
    logic [WORD_W-1:0] w;
    logic [GROUP_W-1:0] pat;
    int exp_type;
    bit exp_tm;

    wait_n(4);
    @(negedge clk); rst = 1'b0;
    wait_n(1);
    // R1 reset state
    chk(cyc_valid == 0 && test_mode == 0 && dq_oe == 0, "R1 reset outputs",
        {cyc_valid, test_mode, dq_oe}, 0);

    // sweep: starting flag x strobe levels at row fall x column pulse
    for (int tm0 = 0; tm0 < 2; tm0++) begin
      for (int cw = 0; cw < 4; cw++) begin
        for (int p = 0; p < 2; p++) begin
          if (tm0 == 1) row_cycle(1'b0, 1'b0, 1'b0, 1'b1);
          else          row_cycle(1'b1, 1'b1, 1'b0, 1'b1);
          ncls = 0;
          row_cycle(cw[1], cw[0], p[0], 1'b1);
          if (!cw[1]) begin
            exp_type = cw[0] ? 2 : 3;
            exp_tm   = !cw[0];
          end else if (p == 1) begin
            exp_type = 0;
            exp_tm   = tm0[0];
          end else begin
            exp_type = 1;
            exp_tm   = 0;
          end
          if (exp_type == 2)      chk(ncls == 1 && last_type == 2, "R2 refresh code", last_type, 2);
          else if (exp_type == 3) chk(ncls == 1 && last_type == 3, "R3 entry code", last_type, 3);
          else if (exp_type == 0) chk(ncls == 1 && last_type == 0, "R6 access code", last_type, 0);
          else                    chk(ncls == 1 && last_type == 1, "R5 row-only code", last_type, 1);
          if (exp_type == 0)      chk(test_mode == exp_tm, "R4 flag kept", test_mode, exp_tm);
          else if (exp_type == 3) chk(test_mode == exp_tm, "R3 flag set", test_mode, exp_tm);
          else                    chk(test_mode == exp_tm, "R5 flag cleared", test_mode, exp_tm);
        end
      end
    end

    // R2: both strobes fall in the same sample
    row_cycle(1'b1, 1'b1, 1'b0, 1'b1);
    ncls = 0;
    @(negedge clk); we_n = 1'b1; ras_n = 1'b0; cas_n = 1'b0;
    wait_n(6); ras_n = 1'b1; wait_n(4); cas_n = 1'b1; wait_n(4);
    chk(ncls == 1 && last_type == 2, "R2 simultaneous fall", last_type, 2);

    // R2: hidden refresh, column strobe held low across the row precharge
    ncls = 0;
    @(negedge clk); ras_n = 1'b0; wait_n(4);
    cas_n = 1'b0; wait_n(4);
    ras_n = 1'b1; wait_n(4);
    ras_n = 1'b0; wait_n(5);
    ras_n = 1'b1; wait_n(4); cas_n = 1'b1; wait_n(4);
    chk(ncls == 2 && last_type == 2, "R2 hidden refresh", last_type, 2);

    // R6: page cycle with two column pulses -> one access report
    ncls = 0;
    @(negedge clk); ras_n = 1'b0; wait_n(4);
    cas_n = 1'b0; wait_n(5); cas_n = 1'b1; wait_n(4);
    cas_n = 1'b0; wait_n(5); cas_n = 1'b1; wait_n(4);
    ras_n = 1'b1; wait_n(6);
    chk(ncls == 1 && last_type == 0, "R6 page one report", ncls, 1);

    // R7: normal reads over every column
    pat = 16'hA5C3;
    for (int c = 0; c < GROUP_N; c++) begin
      read_cycle(c[SEL_W-1:0], pat, lat, w);
      chk(lat == 4, "R7 normal latency", lat, 4);
      chk(w == ((pat >> (WORD_W * c)) & 16'hF), "R7 normal word", w, (pat >> (WORD_W * c)) & 16'hF);
      end_row(off_lat);
      chk(off_lat != 0 && off_lat <= 4, "R10 drive off", off_lat, 4);
    end

    // R7: page mode second column returns new word
    read_cycle(2'd1, 16'h1234, lat, w);
    col_lo = 2'd3; rd_group = 16'h9876; cas_n = 1'b0; wait_n(6);
    chk(dq_out == 4'h9, "R7 page second word", dq_out, 9);
    cas_n = 1'b1; wait_n(2);
    end_row(off_lat);

    // enter test mode, then R8 compressed reads
    row_cycle(1'b0, 1'b0, 1'b0, 1'b1);
    chk(test_mode == 1, "R3 entry before test reads", test_mode, 1);
    for (int t = 0; t < 6; t++) begin
      pat = (t == 0) ? 16'hFFFF : (t == 1) ? 16'h0000 :
            (t == 2) ? 16'hFFFE : (t == 3) ? 16'h8000 :
            (t == 4) ? 16'h0100 : 16'hFFFF;
      read_cycle(t[SEL_W-1:0], pat, lat, w);
      chk(lat == 5, "R8 test latency", lat, 5);
      chk(w == ((pat == 16'hFFFF || pat == 16'h0000) ? 4'hF : 4'h0), "R8 test result",
          w, (pat == 16'hFFFF || pat == 16'h0000) ? 15 : 0);
      end_row(off_lat);
    end
    chk(test_mode == 1, "R4 flag after test reads", test_mode, 1);

    // R9: early write leaves drivers off; R4 flag survives the write
    oe_seen = 0;
    row_cycle(1'b1, 1'b1, 1'b1, 1'b0);
    chk(oe_seen == 0, "R9 early write test mode", oe_seen, 0);
    chk(test_mode == 1, "R4 flag after write", test_mode, 1);
    row_cycle(1'b0, 1'b1, 1'b0, 1'b1);
    chk(test_mode == 0, "R5 refresh exit", test_mode, 0);
    oe_seen = 0;
    row_cycle(1'b1, 1'b1, 1'b1, 1'b0);
    chk(oe_seen == 0, "R9 early write normal", oe_seen, 0);

    finish_up();
  end
endmodule